// File: doc/BRIEF.md
# Qualified Edge Event Counter with Self-Stop

This block is one 16-bit counting channel that counts edges on an asynchronous input pin. The pin first passes through a synchronizer. A qualifier then accepts an edge only after the new level has stayed stable for two consecutive samples. Software chooses whether rising edges, falling edges or both are counted.

The counter starts from a programmed start value and steps down by one on every accepted edge. When the value it reaches equals a programmed match value, the channel does four things on its own. It clears its enable bit and sets a sticky match flag. On the next clock it reloads the start value. It then ignores every further edge until software enables it again.

A small register port is used to program the channel and to read it back. It has an address, a write strobe, write data and registered read data. An interrupt output is the match flag gated by a mask bit.

Top module: `edge_count_timer`

## Requirements
- R1: While enabled, each accepted edge of the selected kind decrements the counter by exactly one; the counter wraps from 0x0000 to 0xFFFF.
- R2: The edge select field CTRL[2:1] picks the counted edge: 00 rising only, 01 falling only, 10 or 11 both edges.
- R3: When a decrement produces a value equal to MATCH, the raw match flag (STATUS bit 0) is set and the enable bit (CTRL bit 0) is cleared by hardware. With start 0x000A and match 0x0006, exactly four edges are counted.
- R4: On the clock after a match, the counter is reloaded with the START register value.
- R5: After a match, input edges leave the counter unchanged until software writes 1 to CTRL bit 0; counting then resumes.
- R6: An edge is accepted only if the synchronized input holds its new level for two consecutive clock samples; a level held for a single cycle is not counted.
- R7: The raw match flag stays set until software writes STATUS with bit 0 equal to 1; writing 0 in that bit leaves it set.
- R8: The irq output, also visible as STATUS bit 1, is the raw flag ANDed with the mask bit CTRL[3]; it follows the flag within two clocks.
- R9: A write to START while the channel is disabled also loads the counter; a write while enabled changes only the START register.
- R10: After reset: COUNT reads 0xFFFF, START 0xFFFF, MATCH 0, CTRL 0, STATUS 0 and irq is low.
- R11: Register addresses are 0 CTRL, 1 START, 2 MATCH, 3 COUNT (read only), 4 STATUS. reg_rdata shows the register at reg_addr one clock after the address is applied. Writes take effect on the clock edge where reg_wr is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pin | input | 1 | Asynchronous event input |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq | output | 1 | Masked match interrupt |

## Verification
Some properties are checked by assertions on every cycle. An accepted rising edge must be preceded by two high samples. A match must leave the enable bit clear and, one clock later, the counter equal to START. The counter must hold still while the channel is disabled. The raw flag must not drop without a write-one-to-clear. Other behaviours can only be shown by the bench's scenarios: exact edge counts under each edge select, wrap-around through zero, rejection of one-cycle glitches, resuming after a re-enable, and the different effect of a START write while enabled and while disabled.

// File: rtl/ecnt_pkg.sv
package ecnt_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE  = 2'b00,
    EDGE_FALL  = 2'b01,
    EDGE_BOTH  = 2'b10,
    EDGE_BOTH2 = 2'b11
  } edge_sel_e;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_START  = 3'd1;
  localparam logic [ADDR_W-1:0] A_MATCH  = 3'd2;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;
endpackage

// File: rtl/ecnt_edge_qual.sv
module ecnt_edge_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD        = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int RW = $clog2(HOLD + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   samp;
  logic                   lvl_q;
  logic [RW-1:0]          run_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= pin_i;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign samp = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= 1'b0;
      run_q  <= '0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (samp != lvl_q) begin
        if (run_q == RW'(HOLD - 1)) begin
          lvl_q  <= samp;
          run_q  <= '0;
          rise_o <= samp;
          fall_o <= ~samp;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  generate
    if (HOLD >= 2) begin : g_chk
      // R6: an accepted rising edge saw two high samples in a row
      assert_rise_width_R6: assert property (@(posedge clk) disable iff (rst)
        rise_o |-> ($past(samp) && $past(samp, 2)));
      // R6: an accepted falling edge saw two low samples in a row
      assert_fall_width_R6: assert property (@(posedge clk) disable iff (rst)
        fall_o |-> (!$past(samp) && !$past(samp, 2)));
    end
  endgenerate
endmodule

// File: rtl/ecnt_core.sv
module ecnt_core
  import ecnt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic [1:0]    sel_i,
  input  logic [CW-1:0] start_i,
  input  logic [CW-1:0] match_i,
  input  logic          start_we_i,
  input  logic [CW-1:0] start_wdata_i,
  input  logic          ctrl_we_i,
  input  logic          ctrl_en_i,
  output logic [CW-1:0] count_o,
  output logic          en_o,
  output logic          hit_o
);
  logic          qual;
  logic [CW-1:0] dec;
  logic          hit_now;

  always_comb begin
    case (sel_i)
      EDGE_RISE: qual = rise_i;
      EDGE_FALL: qual = fall_i;
      default:   qual = rise_i | fall_i;
    endcase
  end

  assign dec     = count_o - 1'b1;
  assign hit_now = en_o && qual && (dec == match_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '1;
      en_o    <= 1'b0;
      hit_o   <= 1'b0;
    end else begin
      hit_o <= hit_now;
      if (ctrl_we_i)    en_o <= ctrl_en_i;
      else if (hit_now) en_o <= 1'b0;

      if (start_we_i && !en_o) count_o <= start_wdata_i;
      else if (hit_o)          count_o <= start_i;
      else if (en_o && qual)   count_o <= dec;
    end
  end

  // R3: a match leaves the channel disabled unless software wrote CTRL
  assert_self_stop_R3: assert property (@(posedge clk) disable iff (rst)
    (hit_o && !$past(ctrl_we_i)) |-> !en_o);
  // R4: the clock after a match reloads the start value
  assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
    (hit_o && !start_we_i) |=> (count_o == $past(start_i)));
  // R5: a disabled channel does not move its counter
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!en_o && !start_we_i && !hit_o) |=> $stable(count_o));
endmodule

// File: rtl/ecnt_regs.sv
module ecnt_regs
  import ecnt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [CW-1:0]     wdata_i,
  input  logic [CW-1:0]     count_i,
  input  logic              en_i,
  input  logic              hit_i,
  output logic [CW-1:0]     start_o,
  output logic [CW-1:0]     match_o,
  output logic [1:0]        sel_o,
  output logic              start_we_o,
  output logic              ctrl_we_o,
  output logic              ctrl_en_o,
  output logic [CW-1:0]     rdata_o,
  output logic              irq_o
);
  logic mask_q;
  logic raw_q;
  logic clr_req;
  logic [CW-1:0] rd_mux;

  assign start_we_o = wr_i && (addr_i == A_START);
  assign ctrl_we_o  = wr_i && (addr_i == A_CTRL);
  assign ctrl_en_o  = wdata_i[0];
  assign clr_req    = wr_i && (addr_i == A_STATUS) && wdata_i[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      start_o <= '1;
      match_o <= '0;
      sel_o   <= EDGE_RISE;
      mask_q  <= 1'b0;
      raw_q   <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      if (start_we_o) start_o <= wdata_i;
      if (wr_i && (addr_i == A_MATCH)) match_o <= wdata_i;
      if (ctrl_we_o) begin
        sel_o  <= wdata_i[2:1];
        mask_q <= wdata_i[3];
      end
      if (hit_i)        raw_q <= 1'b1;
      else if (clr_req) raw_q <= 1'b0;
      irq_o <= raw_q && mask_q;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      A_CTRL:   rd_mux[3:0] = {mask_q, sel_o, en_i};
      A_START:  rd_mux = start_o;
      A_MATCH:  rd_mux = match_o;
      A_COUNT:  rd_mux = count_i;
      A_STATUS: rd_mux[1:0] = {raw_q && mask_q, raw_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_mux;
  end

  // R3: a match from the counter always sets the raw flag
  assert_flag_set_R3: assert property (@(posedge clk) disable iff (rst)
    hit_i |=> raw_q);
  // R7: the raw flag only drops through a write-one-to-clear
  assert_w1c_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (raw_q && !clr_req) |=> raw_q);
endmodule

// File: rtl/edge_count_timer.sv
module edge_count_timer
  import ecnt_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD        = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt_pin,
  input  logic [2:0]    reg_addr,
  input  logic          reg_wr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  output logic          irq
);
  logic          rise, fall;
  logic [1:0]    sel;
  logic [CW-1:0] start_v, match_v, count_v;
  logic          start_we, ctrl_we, ctrl_en, en, hit;

  ecnt_edge_qual #(.SYNC_STAGES(SYNC_STAGES), .HOLD(HOLD)) u_qual (
    .clk(clk), .rst(rst), .pin_i(evt_pin), .rise_o(rise), .fall_o(fall)
  );

  ecnt_core #(.CW(CW)) u_core (
    .clk(clk), .rst(rst), .rise_i(rise), .fall_i(fall), .sel_i(sel),
    .start_i(start_v), .match_i(match_v), .start_we_i(start_we),
    .start_wdata_i(reg_wdata), .ctrl_we_i(ctrl_we), .ctrl_en_i(ctrl_en),
    .count_o(count_v), .en_o(en), .hit_o(hit)
  );

  ecnt_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst(rst), .addr_i(reg_addr), .wr_i(reg_wr),
    .wdata_i(reg_wdata), .count_i(count_v), .en_i(en), .hit_i(hit),
    .start_o(start_v), .match_o(match_v), .sel_o(sel),
    .start_we_o(start_we), .ctrl_we_o(ctrl_we), .ctrl_en_o(ctrl_en),
    .rdata_o(reg_rdata), .irq_o(irq)
  );
endmodule

// File: tb/test_edge_count_timer.sv
module test_edge_count_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_pin = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  edge_count_timer i_edge_count_timer (
    .clk(clk), .rst(rst), .evt_pin(evt_pin), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct packed {
    logic [15:0] start;
    logic [15:0] match;
    logic [1:0]  sel;
    logic [7:0]  npulse;
    logic [15:0] exp_cnt;
    logic        exp_flag;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{16'h000A, 16'h0006, 2'b10, 8'd4, 16'h000A, 1'b1},
    '{16'h000A, 16'h0000, 2'b00, 8'd3, 16'h0007, 1'b0},
    '{16'h000A, 16'h0000, 2'b01, 8'd3, 16'h0007, 1'b0},
    '{16'h0005, 16'h0002, 2'b00, 8'd5, 16'h0005, 1'b1},
    '{16'h0001, 16'hFFFE, 2'b00, 8'd3, 16'h0001, 1'b1},
    '{16'h0014, 16'h0000, 2'b11, 8'd3, 16'h000E, 1'b0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); evt_pin = 1'b1;
      repeat (4) @(negedge clk);
      evt_pin = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !done) begin
        done = 1'b1;
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R10 reset state, addresses per R11
    rd(3'd3, v); check("R10 count", v, 16'hFFFF);
    rd(3'd1, v); check("R10 start", v, 16'hFFFF);
    rd(3'd2, v); check("R10 match", v, 16'h0000);
    rd(3'd0, v); check("R10 ctrl", v, 16'h0000);
    rd(3'd4, v); check("R10 status", v, 16'h0000);
    check("R10 irq", {15'd0, irq}, 16'h0000);

    // R1 R2 R3 R4: vector walk
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, 16'h0000);
      wr(3'd1, VECS[i].start);
      wr(3'd2, VECS[i].match);
      wr(3'd4, 16'h0001);
      rd(3'd3, v); check("R9 load while disabled", v, VECS[i].start);
      wr(3'd0, {13'd0, VECS[i].sel, 1'b1});
      pulses(int'(VECS[i].npulse));
      rd(3'd3, v); check("R1 R2 R4 count", v, VECS[i].exp_cnt);
      rd(3'd4, v); check("R3 flag", {15'd0, v[0]}, {15'd0, VECS[i].exp_flag});
      rd(3'd0, v); check("R3 enable", {15'd0, v[0]}, {15'd0, ~VECS[i].exp_flag});
    end

    // R6 glitch rejection
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h000A);
    wr(3'd2, 16'h0000);
    wr(3'd0, 16'h0001);
    @(negedge clk); evt_pin = 1'b1;
    @(negedge clk); evt_pin = 1'b0;
    repeat (10) @(negedge clk);
    rd(3'd3, v); check("R6 one-cycle glitch", v, 16'h000A);
    @(negedge clk); evt_pin = 1'b1;
    repeat (2) @(negedge clk); evt_pin = 1'b0;
    repeat (10) @(negedge clk);
    rd(3'd3, v); check("R6 two-cycle level", v, 16'h0009);

    // R5 R8: stop with mask, later edges ignored
    wr(3'd0, 16'h0000);
    wr(3'd4, 16'h0001);
    wr(3'd1, 16'h0003);
    wr(3'd2, 16'h0001);
    wr(3'd0, 16'h0009);
    pulses(2);
    rd(3'd3, v); check("R4 reload", v, 16'h0003);
    check("R8 irq set", {15'd0, irq}, 16'h0001);
    pulses(2);
    rd(3'd3, v); check("R5 ignored edges", v, 16'h0003);
    rd(3'd4, v); check("R8 status masked bit", v, 16'h0003);

    // R7 write-one-to-clear
    wr(3'd4, 16'h0000);
    rd(3'd4, v); check("R7 write zero keeps flag", {15'd0, v[0]}, 16'h0001);
    wr(3'd4, 16'h0001);
    repeat (2) @(negedge clk);
    rd(3'd4, v); check("R7 cleared", v, 16'h0000);
    check("R8 irq cleared", {15'd0, irq}, 16'h0000);

    // R5 resume after re-enable, mask off
    wr(3'd0, 16'h0001);
    pulses(1);
    rd(3'd3, v); check("R5 resumed", v, 16'h0002);

    // R9 start write while enabled leaves counter
    wr(3'd1, 16'h0050);
    rd(3'd3, v); check("R9 enabled write", v, 16'h0002);
    pulses(1);
    rd(3'd3, v); check("R4 reload new start", v, 16'h0050);
    rd(3'd4, v); check("R8 mask off status", v, 16'h0001);
    check("R8 mask off irq", {15'd0, irq}, 16'h0000);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule